// File: doc/BRIEF.md
# Serial avionics word receiver

This block recovers 32-bit words from a three-level, return-to-zero avionics data line that an analog front end has already split into two logic signals: one high for a "one" level, one high for a "zero" level, both low for null. A system clock is divided down to a sample strobe at ten times the selected bit rate. Each sample is classified as one, zero, null or conflict, and each of one, zero and null is kept in its own sampling register. A bit is taken when a run of one or zero samples returns to null. A null-run timer decides whether the line has been quiet long enough for a new word to begin.

When the thirty-second bit lands, the block updates a 32-bit output word and raises a single-cycle end-of-sequence pulse. The first bit received sits in the least significant position. The top bit of the output does not carry the received parity bit. It carries a flag that is 0 when the 32 received bits held an odd number of ones and 1 otherwise. A word with bad parity is still delivered. A rate-select input picks the high-speed or low-speed sample divider.

Top module: `arinc_word_rx`

## Requirements
- R1: While reset is asserted (rst_n low), word_o reads 0 and eos_o reads 0.
- R2: The first received bit is stored at word_o[0] and received bit k at word_o[k-1] for k up to 31. eos_o pulses once per complete 32-bit word.
- R3: word_o[31] is 0 when the 32 received bits (including the received bit 32) contain an odd number of ones, and 1 when they contain an even number. Both kinds of word are delivered.
- R4: A bit is accepted only after at least 3 consecutive samples at the same level (one or zero), followed by a null sample. A pulse of 2 samples is ignored, and the bits around it are still assembled into the word.
- R5: A word can start only after a run of at least 40 consecutive null samples (4 bit times at 10 samples per bit), counted from the first null after the previous pulse. With 39 null samples, every bit of the following word is ignored and no pulse follows. With 40, the word is received.
- R6: A null run that reaches 40 samples in the middle of a word discards the partial word. The next full word is then received alone and intact.
- R7: A sample with both line inputs high clears the bit count and the gap credit. The bits that follow, before a new 40-sample null run, produce no eos_o.
- R8: With rate_sel_i = 0 the line is sampled every DIV_HI clocks, and with rate_sel_i = 1 every DIV_LO clocks. Words timed for the selected rate are received. With rate_sel_i = 1, pulses timed for the high rate are too short to be accepted.
- R9: eos_o is never high for two cycles in a row. word_o changes only in a cycle where eos_o is high and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_sel_i | input | 1 | 0 selects the high bit rate, 1 the low bit rate |
| line_one_i | input | 1 | High while the line is at the "one" level |
| line_zero_i | input | 1 | High while the line is at the "zero" level |
| word_o | output | 32 | Last received word, with bit 31 replaced by the parity-error flag |
| eos_o | output | 1 | One-cycle pulse when word_o takes a new word |

## Verification
The sample that completes the thirty-second bit is also the first null sample of the next gap. So in one strobe the word is delivered, the gap credit is cleared, and the null-run count starts again from one. The bench provokes this by following a word with 34 and then with 35 extra null samples. This puts the next word's first pulse just before and exactly at the 40-sample threshold. The result is judged by whether exactly one or exactly two pulses appear, and by the held word value. A second meeting point is the mid-word gap abort against a partly assembled word. There, the pulse count and the delivered value show that no bit from the abandoned word leaked into the next one.

// File: rtl/arinc_rx_pkg.sv
// Shared constants and types for the serial avionics word receiver.
package arinc_rx_pkg;

    localparam int WORD_BITS   = 32;
    localparam int SMP_PER_BIT = 10;
    localparam int RUN_LEN     = 3;
    localparam int GAP_BITS    = 4;
    localparam int GAP_SMP     = GAP_BITS * SMP_PER_BIT;

    // Line level as seen on {one, zero}
    typedef enum logic [1:0] {
        LN_NULL = 2'b00,
        LN_ZERO = 2'b01,
        LN_ONE  = 2'b10,
        LN_BAD  = 2'b11
    } line_e;

endpackage

// File: rtl/arinc_rx_tick.sv
// Sample strobe generator.
// Produces a one-cycle strobe every DIV_HI or DIV_LO clocks, picked by
// rate_sel_i. Assumes both divisors are at least 1. A change of rate takes
// effect at the next strobe boundary.
module arinc_rx_tick #(
    parameter int DIV_HI = 50,
    parameter int DIV_LO = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel_i,
    output logic tick_o
);
    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CW      = $clog2(DIV_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Terminal count for the selected rate
    always_comb limit = rate_sel_i ? CW'(DIV_LO - 1) : CW'(DIV_HI - 1);

    // Count clocks and emit the strobe at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/arinc_rx_sampler.sv
// Line sampler.
// Synchronises the two line inputs and classifies each strobed sample.
// Ones and zeros go into run registers of RUN_LEN samples; null goes into a
// one-deep register. A conflict is a sample that is none of the three.
// Assumes RUN_LEN >= 2. Outputs are valid in the cycle stb_o is high.
module arinc_rx_sampler
    import arinc_rx_pkg::*;
#(
    parameter int RUN_LEN_P = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic one_i,
    input  logic zero_i,
    output logic stb_o,
    output logic run_one_o,
    output logic run_zero_o,
    output logic null_o,
    output logic conflict_o
);
    logic [1:0] one_sync_q;
    logic [1:0] zero_sync_q;
    line_e      cur;
    logic       null_q;

    // Two-stage synchronisers on both line inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            one_sync_q  <= '0;
            zero_sync_q <= '0;
        end else begin
            one_sync_q  <= {one_sync_q[0], one_i};
            zero_sync_q <= {zero_sync_q[0], zero_i};
        end
    end

    // Current line level after synchronisation
    always_comb cur = line_e'({one_sync_q[1], zero_sync_q[1]});

    // One run register per active level (0: one, 1: zero)
    for (genvar k = 0; k < 2; k++) begin : g_run
        localparam line_e KIND = (k == 0) ? LN_ONE : LN_ZERO;
        logic [RUN_LEN_P-1:0] sr;

        // Shift in whether this sample matches the level
        always_ff @(posedge clk) begin
            if (!rst_n)      sr <= '0;
            else if (tick_i) sr <= {sr[RUN_LEN_P-2:0], cur == KIND};
        end
    end

    // Null register, idle line assumed at reset
    always_ff @(posedge clk) begin
        if (!rst_n)      null_q <= 1'b1;
        else if (tick_i) null_q <= (cur == LN_NULL);
    end

    // Strobe delayed by one cycle so the registers already hold the sample
    always_ff @(posedge clk) begin
        if (!rst_n) stb_o <= 1'b0;
        else        stb_o <= tick_i;
    end

    // Classified view of the newest sample and of the runs
    always_comb begin
        run_one_o  = &g_run[0].sr;
        run_zero_o = &g_run[1].sr;
        null_o     = null_q;
        conflict_o = ~(g_run[0].sr[0] | g_run[1].sr[0] | null_q);
    end
endmodule

// File: rtl/arinc_rx_assembler.sv
// Word assembler.
// Arms on a run of one or zero samples, takes the bit on the next null,
// counts bits, times the null gap, and delivers the word with its parity
// flag. A conflict sample or a full-length null run in mid-word drops the
// partial word. Assumes GAP_SMP_P >= 2 and inputs qualified by stb_i.
module arinc_rx_assembler
    import arinc_rx_pkg::*;
#(
    parameter int WORD_BITS_P = WORD_BITS,
    parameter int GAP_SMP_P   = GAP_SMP
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stb_i,
    input  logic                         run_one_i,
    input  logic                         run_zero_i,
    input  logic                         null_i,
    input  logic                         conflict_i,
    output logic [$clog2(WORD_BITS_P)-1:0] bit_cnt_o,
    output logic [WORD_BITS_P-1:0]       word_o,
    output logic                         eos_o
);
    localparam int CNT_W  = $clog2(WORD_BITS_P);
    localparam int NULL_W = $clog2(GAP_SMP_P + 1);

    logic [CNT_W-1:0]       bit_cnt_q;
    logic [NULL_W-1:0]      null_cnt_q;
    logic                   gap_ok_q;
    logic                   armed_q;
    logic                   arm_val_q;
    logic [WORD_BITS_P-1:0] shreg_q;

    logic                   bad_smp;
    logic                   null_smp;
    logic                   accept;
    logic                   take;
    logic                   last;
    logic                   gap_hit;
    logic [WORD_BITS_P-1:0] full;

    // Qualified events for this sample
    always_comb begin
        bad_smp  = stb_i && conflict_i;
        null_smp = stb_i && null_i && !conflict_i;
        accept   = null_smp && armed_q;
        take     = accept && ((bit_cnt_q != '0) || gap_ok_q);
        last     = take && (bit_cnt_q == CNT_W'(WORD_BITS_P - 1));
        gap_hit  = null_smp && (null_cnt_q == NULL_W'(GAP_SMP_P - 1));
        full     = {arm_val_q, shreg_q[WORD_BITS_P-1:1]};
    end

    // Length of the current null run, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n)                             null_cnt_q <= '0;
        else if (stb_i && !null_smp)            null_cnt_q <= '0;
        else if (null_smp && null_cnt_q != NULL_W'(GAP_SMP_P))
                                                null_cnt_q <= null_cnt_q + 1'b1;
    end

    // Gap credit: earned by a full null run, spent by any taken bit
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_ok_q <= 1'b0;
        else if (bad_smp || accept) gap_ok_q <= 1'b0;
        else if (gap_hit)           gap_ok_q <= 1'b1;
    end

    // Arm on a qualifying run, disarm on null or conflict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            arm_val_q <= 1'b0;
        end else if (stb_i) begin
            if (conflict_i || null_i) begin
                armed_q <= 1'b0;
            end else if (run_one_i) begin
                armed_q   <= 1'b1;
                arm_val_q <= 1'b1;
            end else if (run_zero_i) begin
                armed_q   <= 1'b1;
                arm_val_q <= 1'b0;
            end
        end
    end

    // Bit position within the word
    always_ff @(posedge clk) begin
        if (!rst_n)                bit_cnt_q <= '0;
        else if (bad_smp || gap_hit) bit_cnt_q <= '0;
        else if (last)             bit_cnt_q <= '0;
        else if (take)             bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // Shift taken bits in from the top so the first ends at bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg_q <= '0;
        else if (take) shreg_q <= full;
    end

    // Deliver the word with the parity flag in the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            eos_o  <= 1'b0;
        end else begin
            eos_o <= last;
            if (last) word_o <= {~(^full), full[WORD_BITS_P-2:0]};
        end
    end

    always_comb bit_cnt_o = bit_cnt_q;
endmodule

// File: rtl/arinc_word_rx.sv
// Serial avionics word receiver, top level.
// Chains the strobe generator, the line sampler and the word assembler.
// Assumes the line inputs are clean logic levels from an external front end.
module arinc_word_rx
    import arinc_rx_pkg::*;
#(
    parameter int DIV_HI = 50,
    parameter int DIV_LO = 400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rate_sel_i,
    input  logic        line_one_i,
    input  logic        line_zero_i,
    output logic [31:0] word_o,
    output logic        eos_o
);
    localparam int CNT_W = $clog2(WORD_BITS);

    logic             tick;
    logic             smp_stb;
    logic             smp_run_one;
    logic             smp_run_zero;
    logic             smp_null;
    logic             smp_conflict;
    logic [CNT_W-1:0] bit_cnt;

    arinc_rx_tick #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel_i (rate_sel_i),
        .tick_o     (tick)
    );

    arinc_rx_sampler #(.RUN_LEN_P(RUN_LEN)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .one_i      (line_one_i),
        .zero_i     (line_zero_i),
        .stb_o      (smp_stb),
        .run_one_o  (smp_run_one),
        .run_zero_o (smp_run_zero),
        .null_o     (smp_null),
        .conflict_o (smp_conflict)
    );

    arinc_rx_assembler #(.WORD_BITS_P(WORD_BITS), .GAP_SMP_P(GAP_SMP)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (smp_stb),
        .run_one_i  (smp_run_one),
        .run_zero_i (smp_run_zero),
        .null_i     (smp_null),
        .conflict_i (smp_conflict),
        .bit_cnt_o  (bit_cnt),
        .word_o     (word_o),
        .eos_o      (eos_o)
    );
endmodule

// File: rtl/arinc_word_rx_chk.sv
// Property checker for the serial avionics word receiver, bound to the top.
module arinc_word_rx_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic             conflict,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [31:0]      word,
    input logic             eos
);
    // R9: the end-of-sequence pulse lasts one cycle
    assert_eos_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eos |=> !eos);

    // R9: the output word moves only together with the pulse
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eos |-> $stable(word));

    // R7: a conflict sample leaves the bit count at zero
    assert_conflict_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && conflict) |=> (bit_cnt == '0));

    // R2: a word completes only on a sample strobe
    assert_eos_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> $past(smp_stb));

    // R4: the bit count never moves between sample strobes
    assert_count_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(bit_cnt));
endmodule

bind arinc_word_rx arinc_word_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .conflict (smp_conflict),
    .bit_cnt  (bit_cnt),
    .word     (word_o),
    .eos      (eos_o)
);

// File: tb/sim_arinc_word_rx.sv
module sim_arinc_word_rx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HI     = 2;
    localparam int DIV_LO     = 5;
    localparam int ON_SMP     = 5;
    localparam int GAP_STD    = 36;
    localparam int WDOG       = 190000;

    logic        clk;
    logic        rst_n;
    logic        rate_sel_i;
    logic        line_one_i;
    logic        line_zero_i;
    logic [31:0] word_o;
    logic        eos_o;

    int          n_checks = 0;
    int          n_err    = 0;
    int          eos_cnt  = 0;
    int          eos_wide = 0;
    logic        prev_eos = 1'b0;
    logic [31:0] cap      = '0;
    int          div_now  = DIV_HI;
    int          base;
    logic [31:0] w;

    arinc_word_rx #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel_i  (rate_sel_i),
        .line_one_i  (line_one_i),
        .line_zero_i (line_zero_i),
        .word_o      (word_o),
        .eos_o       (eos_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Pulse monitor sampled away from the active edge
    always @(negedge clk) begin
        if (eos_o) begin
            eos_cnt = eos_cnt + 1;
            cap     = word_o;
        end
        if (eos_o && prev_eos) eos_wide = eos_wide + 1;
        prev_eos = eos_o;
    end

    function automatic logic [31:0] exp_of(input logic [31:0] v);
        return {~(^v), v[30:0]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic o, input logic z, input int nsmp);
        line_one_i  = o;
        line_zero_i = z;
        repeat (nsmp * div_now) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int lo, input int hi, input int on);
        for (int i = lo; i <= hi; i++) begin
            drive(v[i], ~v[i], on);
            drive(1'b0, 1'b0, 10 - on);
        end
    endtask

    task automatic send_word(input logic [31:0] v);
        send_bits(v, 0, 31, ON_SMP);
        drive(1'b0, 1'b0, GAP_STD);
    endtask

    task automatic rx_word(input logic [31:0] v, input string tag);
        int b;
        b = eos_cnt;
        send_word(v);
        check(eos_cnt == b + 1, tag, 32'(eos_cnt - b), 32'd1);
        check(cap == exp_of(v), tag, cap, exp_of(v));
        check(cap[31] == ~(^v), "R3", {31'd0, cap[31]}, {31'd0, ~(^v)});
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WDOG) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        rate_sel_i  = 1'b0;
        line_one_i  = 1'b0;
        line_zero_i = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset values
        check(word_o == 32'd0, "R1", word_o, 32'd0);
        check(eos_o == 1'b0, "R1", {31'd0, eos_o}, 32'd0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 50);

        // R2 / R3: walking ones, walking zeros, extremes, pseudo-random words
        for (int i = 0; i < 32; i++) rx_word(32'd1 << i, "R2");
        for (int i = 0; i < 32; i++) rx_word(~(32'd1 << i), "R2");
        rx_word(32'h0000_0000, "R3");
        rx_word(32'hFFFF_FFFF, "R3");
        w = 32'h1357_9BDF;
        for (int i = 0; i < 12; i++) begin
            w = w * 32'd1664525 + 32'd1013904223;
            rx_word(w, "R2");
        end

        // R4: three-sample pulses are enough
        base = eos_cnt;
        send_bits(32'hA5C3_0F96, 0, 31, 3);
        drive(1'b0, 1'b0, GAP_STD);
        check(eos_cnt == base + 1, "R4", 32'(eos_cnt - base), 32'd1);
        check(cap == exp_of(32'hA5C3_0F96), "R4", cap, exp_of(32'hA5C3_0F96));

        // R4: a two-sample pulse inside a word is ignored
        base = eos_cnt;
        send_bits(32'h3C96_E1D2, 0, 9, ON_SMP);
        drive(1'b1, 1'b0, 2);
        drive(1'b0, 1'b0, 3);
        send_bits(32'h3C96_E1D2, 10, 31, ON_SMP);
        drive(1'b0, 1'b0, GAP_STD);
        check(eos_cnt == base + 1, "R4", 32'(eos_cnt - base), 32'd1);
        check(cap == exp_of(32'h3C96_E1D2), "R4", cap, exp_of(32'h3C96_E1D2));

        // R5: 39 null samples after a word are too few
        base = eos_cnt;
        send_bits(32'h1111_2222, 0, 31, ON_SMP);
        drive(1'b0, 1'b0, 34);
        send_word(32'h7777_8888);
        check(eos_cnt == base + 1, "R5", 32'(eos_cnt - base), 32'd1);
        // R9: the dropped word leaves the last output untouched
        check(cap == exp_of(32'h1111_2222), "R9", cap, exp_of(32'h1111_2222));
        check(word_o == exp_of(32'h1111_2222), "R9", word_o, exp_of(32'h1111_2222));
        rx_word(32'h0F0F_1234, "R5");

        // R5: exactly 40 null samples are enough
        base = eos_cnt;
        send_bits(32'h2468_ACE0, 0, 31, ON_SMP);
        drive(1'b0, 1'b0, 35);
        send_word(32'h1357_9BDE);
        check(eos_cnt == base + 2, "R5", 32'(eos_cnt - base), 32'd2);
        check(cap == exp_of(32'h1357_9BDE), "R5", cap, exp_of(32'h1357_9BDE));

        // R6: a long null in mid-word drops the partial word
        base = eos_cnt;
        send_bits(32'hFFFF_FFFF, 0, 9, ON_SMP);
        drive(1'b0, 1'b0, GAP_STD);
        send_word(32'h5A5A_0001);
        check(eos_cnt == base + 1, "R6", 32'(eos_cnt - base), 32'd1);
        check(cap == exp_of(32'h5A5A_0001), "R6", cap, exp_of(32'h5A5A_0001));

        // R7: a conflict sample restarts the word and needs a new gap
        base = eos_cnt;
        send_bits(32'hC0DE_5EED, 0, 9, ON_SMP);
        drive(1'b1, 1'b1, 2);
        drive(1'b0, 1'b0, 5);
        send_bits(32'hC0DE_5EED, 10, 31, ON_SMP);
        drive(1'b0, 1'b0, GAP_STD);
        check(eos_cnt == base, "R7", 32'(eos_cnt - base), 32'd0);
        rx_word(32'h8000_7FFF, "R7");

        // R8: low-rate words with the low-rate divider
        rate_sel_i = 1'b1;
        div_now    = DIV_LO;
        drive(1'b0, 1'b0, 50);
        rx_word(32'h0000_0001, "R8");
        rx_word(32'hDEAD_BEEF, "R8");
        rx_word(32'h8000_0000, "R8");

        // R8: high-rate timing is too short at the low rate
        base    = eos_cnt;
        div_now = DIV_HI;
        send_word(32'h1234_5678);
        check(eos_cnt == base, "R8", 32'(eos_cnt - base), 32'd0);
        div_now = DIV_LO;
        drive(1'b0, 1'b0, 50);
        rx_word(32'h6B6B_0C0C, "R8");

        // R8: back to the high rate
        rate_sel_i = 1'b0;
        div_now    = DIV_HI;
        drive(1'b0, 1'b0, 50);
        rx_word(32'hFACE_0420, "R8");

        // R9: no pulse lasted two cycles
        check(eos_wide == 0, "R9", 32'(eos_wide), 32'd0);

        summary();
        $finish;
    end
endmodule